// File: doc/BRIEF.md
# Saturating Bounded Clamp with Latency Line

This block bounds a stream of 32-bit signed integer samples. Each sample is first held between a floor and a ceiling that arrive on input ports. Both bounds may take any signed value, negative ones included. The bounded value may then be squeezed into a narrower signed or unsigned range chosen at elaboration. A third choice keeps the full 32-bit signed result.

The result leaves the block through a pipeline with a fixed number of register stages. It is 32 bits wide and signed. All registers move on the active clock edge only, which is the rising edge or the falling edge depending on a parameter. A synchronous reset loads every stage with a programmable start value. That value stays on the output until the first real sample has crossed the whole pipeline.

Top module: `sat_clamp_delay`

## Requirements
- R1: In full-width mode, a sample with lim_lo <= sample <= lim_hi appears on dout unchanged.
- R2: A sample above lim_hi appears on dout as lim_hi.
- R3: When lim_lo <= lim_hi, a sample below lim_lo appears on dout as lim_lo.
- R4: When lim_lo > lim_hi, dout equals lim_hi for every sample.
- R5: Both bounds may be negative, and clamping to such bounds follows R1 to R3.
- R6: In signed mode with width W, the bounded value is saturated into -2^(W-1) .. 2^(W-1)-1 after the bounds are applied.
- R7: In unsigned mode with width W, a bounded value below 0 becomes 0 and one above 2^W-1 becomes 2^W-1.
- R8: A sample captured on an active edge appears on dout exactly DELAY active edges later, and dout does not change on the inactive edge.
- R9: While rst is high and for the first DELAY-1 active edges after it falls, dout equals INIT_VAL.
- R10: With FALL_EDGE set, dout changes only on falling clock edges, and the reset is sampled on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the active edge is set by FALL_EDGE |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DW | Signed input sample |
| lim_hi | input | DW | Signed upper bound (ceiling) |
| lim_lo | input | DW | Signed lower bound (floor) |
| dout | output | DW | Signed delayed and saturated result |

## Verification
The bound checks assume that both limits stay constant for at least DELAY active edges. A stability counter in the checker enforces this and switches the check off while it is counting. The range checks assume that INIT_VAL lies inside the saturated range, because the counter only stops excusing the start value after DELAY edges. The stimulus keeps each pair of limits for a full sweep of 41 samples and chooses start values inside each instance's range. Inputs change two nanoseconds after a rising edge, so both edges of every cycle see the same value.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

    typedef enum logic [1:0] {
        MODE_FULL     = 2'd0,
        MODE_SIGNED   = 2'd1,
        MODE_UNSIGNED = 2'd2
    } out_mode_e;

    // Upper end of the saturated range for a mode and bit width.
    function automatic longint sat_hi(out_mode_e m, int w);
        if (m == MODE_SIGNED) return (longint'(1) <<< (w - 1)) - 1;
        return (longint'(1) <<< w) - 1;
    endfunction

    // Lower end of the saturated range for a mode and bit width.
    function automatic longint sat_lo(out_mode_e m, int w);
        if (m == MODE_SIGNED) return -(longint'(1) <<< (w - 1));
        return 0;
    endfunction

endpackage

// File: rtl/clamp_bounds.sv
module clamp_bounds #(
    parameter int DW = 32
) (
    input  logic signed [DW-1:0] smp,
    input  logic signed [DW-1:0] ceil_v,
    input  logic signed [DW-1:0] floor_v,
    output logic signed [DW-1:0] bnd
);
    logic signed [DW-1:0] raised;

    always_comb begin
        // Floor first, ceiling last: the ceiling wins when the bounds cross.
        raised = (smp < floor_v) ? floor_v : smp;
        bnd    = (raised > ceil_v) ? ceil_v : raised;
    end
endmodule

// File: rtl/clamp_width_sat.sv
module clamp_width_sat
    import clamp_pkg::*;
#(
    parameter int        DW    = 32,
    parameter out_mode_e MODE  = MODE_FULL,
    parameter int        WBITS = 8
) (
    input  logic signed [DW-1:0] val,
    output logic signed [DW-1:0] sat
);
    generate
        if (MODE == MODE_FULL) begin : g_full
            assign sat = val;
        end else begin : g_narrow
            localparam longint HI = sat_hi(MODE, WBITS);
            localparam longint LO = sat_lo(MODE, WBITS);
            localparam logic signed [DW-1:0] HI_V = DW'(HI);
            localparam logic signed [DW-1:0] LO_V = DW'(LO);
            always_comb begin
                if (longint'(val) > HI)      sat = HI_V;
                else if (longint'(val) < LO) sat = LO_V;
                else                         sat = val;
            end
        end
    endgenerate
endmodule

// File: rtl/clamp_delay_line.sv
module clamp_delay_line #(
    parameter int                    DW        = 32,
    parameter int                    DELAY     = 3,
    parameter bit                    FALL_EDGE = 1'b0,
    parameter logic signed [DW-1:0]  INIT_VAL  = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] d,
    output logic signed [DW-1:0] q
);
    typedef struct packed {
        logic [DELAY-1:0][DW-1:0] stg;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (rst) begin
            for (int i = 0; i < DELAY; i++) line_d.stg[i] = INIT_VAL;
        end else begin
            line_d.stg[0] = d;
            for (int i = 1; i < DELAY; i++) line_d.stg[i] = line_q.stg[i-1];
        end
    end

    generate
        if (FALL_EDGE) begin : g_neg
            always_ff @(negedge clk) line_q <= line_d;
        end else begin : g_pos
            always_ff @(posedge clk) line_q <= line_d;
        end
    endgenerate

    assign q = $signed(line_q.stg[DELAY-1]);
endmodule

// File: rtl/sat_clamp_delay.sv
module sat_clamp_delay
    import clamp_pkg::*;
#(
    parameter int                    DW        = 32,
    parameter int                    DELAY     = 3,
    parameter bit                    FALL_EDGE = 1'b0,
    parameter out_mode_e             OUT_MODE  = MODE_FULL,
    parameter int                    OUT_BITS  = 8,
    parameter logic signed [DW-1:0]  INIT_VAL  = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] din,
    input  logic signed [DW-1:0] lim_hi,
    input  logic signed [DW-1:0] lim_lo,
    output logic signed [DW-1:0] dout
);
    logic signed [DW-1:0] bounded;
    logic signed [DW-1:0] narrowed;

    clamp_bounds #(.DW(DW)) u_bounds (
        .smp     (din),
        .ceil_v  (lim_hi),
        .floor_v (lim_lo),
        .bnd     (bounded)
    );

    clamp_width_sat #(.DW(DW), .MODE(OUT_MODE), .WBITS(OUT_BITS)) u_sat (
        .val (bounded),
        .sat (narrowed)
    );

    clamp_delay_line #(
        .DW(DW), .DELAY(DELAY), .FALL_EDGE(FALL_EDGE), .INIT_VAL(INIT_VAL)
    ) u_line (
        .clk (clk),
        .rst (rst),
        .d   (narrowed),
        .q   (dout)
    );
endmodule

// File: rtl/sat_clamp_delay_chk.sv
module sat_clamp_delay_chk
    import clamp_pkg::*;
#(
    parameter int                    DW        = 32,
    parameter int                    DELAY     = 3,
    parameter bit                    FALL_EDGE = 1'b0,
    parameter out_mode_e             OUT_MODE  = MODE_FULL,
    parameter int                    OUT_BITS  = 8,
    parameter logic signed [DW-1:0]  INIT_VAL  = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] lim_hi,
    input  logic signed [DW-1:0] lim_lo,
    input  logic signed [DW-1:0] dout
);
    logic act_clk;
    assign act_clk = FALL_EDGE ? ~clk : clk;

    int unsigned          live_cnt;
    int unsigned          stab_cnt;
    logic signed [DW-1:0] hi_prev, lo_prev;
    logic                 lim_steady;

    always_ff @(posedge act_clk) begin
        if (rst) begin
            live_cnt <= 0;
            stab_cnt <= 0;
        end else begin
            if (live_cnt < DELAY) live_cnt <= live_cnt + 1;
            if (lim_hi == hi_prev && lim_lo == lo_prev) begin
                if (stab_cnt < DELAY) stab_cnt <= stab_cnt + 1;
            end else begin
                stab_cnt <= 0;
            end
        end
        hi_prev <= lim_hi;
        lo_prev <= lim_lo;
    end

    assign lim_steady = (live_cnt >= DELAY) && (stab_cnt >= DELAY)
                        && (lim_hi == hi_prev) && (lim_lo == lo_prev);

    AST_INIT_HOLD: assert property (@(posedge act_clk) disable iff (rst)
        (live_cnt < DELAY) |-> (dout == INIT_VAL)); // R9
    AST_RESET_LOAD: assert property (@(posedge act_clk) disable iff (rst)
        $past(rst) |-> (dout == INIT_VAL)); // R10

    generate
        if (OUT_MODE == MODE_FULL) begin : g_full
            AST_CEILING: assert property (@(posedge act_clk) disable iff (rst)
                lim_steady |-> (dout <= lim_hi)); // R2
            AST_FLOOR: assert property (@(posedge act_clk) disable iff (rst)
                (lim_steady && lim_lo <= lim_hi) |-> (dout >= lim_lo)); // R3
            AST_CROSSED: assert property (@(posedge act_clk) disable iff (rst)
                (lim_steady && lim_lo > lim_hi) |-> (dout == lim_hi)); // R4
        end else if (OUT_MODE == MODE_SIGNED) begin : g_sgn
            localparam longint HI = sat_hi(OUT_MODE, OUT_BITS);
            localparam longint LO = sat_lo(OUT_MODE, OUT_BITS);
            AST_SIGNED_RANGE: assert property (@(posedge act_clk) disable iff (rst)
                (live_cnt >= DELAY) |-> (longint'(dout) <= HI && longint'(dout) >= LO)); // R6
        end else begin : g_uns
            localparam longint HI = sat_hi(OUT_MODE, OUT_BITS);
            AST_UNSIGNED_RANGE: assert property (@(posedge act_clk) disable iff (rst)
                (live_cnt >= DELAY) |-> (longint'(dout) <= HI && longint'(dout) >= 0)); // R7
        end
    endgenerate
endmodule

bind sat_clamp_delay sat_clamp_delay_chk #(
    .DW(DW), .DELAY(DELAY), .FALL_EDGE(FALL_EDGE),
    .OUT_MODE(OUT_MODE), .OUT_BITS(OUT_BITS), .INIT_VAL(INIT_VAL)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .lim_hi (lim_hi),
    .lim_lo (lim_lo),
    .dout   (dout)
);

// File: tb/sat_clamp_delay_bench.sv
module sat_clamp_delay_bench;
    import clamp_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [31:0] din = '0, lim_hi = '0, lim_lo = '0;
    logic signed [31:0] out_s, out_u, out_f;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    int h_x  [0:511];
    int h_hi [0:511];
    int h_lo [0:511];

    always #5 clk = ~clk;

    // Signed W=4, three stages, rising edge
    sat_clamp_delay #(.DELAY(3), .FALL_EDGE(1'b0), .OUT_MODE(MODE_SIGNED),
        .OUT_BITS(4), .INIT_VAL(-32'sd3)) u_sat_clamp_delay (
        .clk(clk), .rst(rst), .din(din), .lim_hi(lim_hi), .lim_lo(lim_lo), .dout(out_s));

    // Unsigned W=3, two stages, falling edge
    sat_clamp_delay #(.DELAY(2), .FALL_EDGE(1'b1), .OUT_MODE(MODE_UNSIGNED),
        .OUT_BITS(3), .INIT_VAL(32'sd5)) u_sat_clamp_delay_uns (
        .clk(clk), .rst(rst), .din(din), .lim_hi(lim_hi), .lim_lo(lim_lo), .dout(out_u));

    // Full width, one stage, rising edge
    sat_clamp_delay #(.DELAY(1), .FALL_EDGE(1'b0), .OUT_MODE(MODE_FULL),
        .OUT_BITS(8), .INIT_VAL(-32'sd7777)) u_sat_clamp_delay_full (
        .clk(clk), .rst(rst), .din(din), .lim_hi(lim_hi), .lim_lo(lim_lo), .dout(out_f));

    function automatic int clampv(int x, int hi, int lo);
        int r;
        r = (x < lo) ? lo : x;
        return (r > hi) ? hi : r;
    endfunction

    function automatic int satv(int v, int lo, int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic int exp_at(int idx, int init, int lo, int hi);
        if (idx < 0) return init;
        return satv(clampv(h_x[idx], h_hi[idx], h_lo[idx]), lo, hi);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string full_tag(int idx);
        if (idx < 0) return "R9";
        if (h_lo[idx] > h_hi[idx]) return "R4";
        if (h_hi[idx] < 0) return "R5";
        if (h_x[idx] > h_hi[idx]) return "R2";
        if (h_x[idx] < h_lo[idx]) return "R3";
        return "R1";
    endfunction

    initial begin
        int s;
        int pair_hi [7] = '{5, 3, 12, -1, 2, 20, 0};
        int pair_lo [7] = '{-2, -9, -12, -6, 6, 10, 0};
        // Reset: hold for three cycles, outputs show the start values
        repeat (3) begin
            @(posedge clk);
            #2;
        end
        #2;
        chk("R9 signed reset", out_s, -3);
        chk("R10 falling reset", out_u, 5);
        chk("R9 full reset", out_f, -7777);
        s = 0;
        for (int p = 0; p < 7; p++) begin
            for (int x = -20; x <= 20; x++) begin
                @(posedge clk);
                #2;
                rst    = 1'b0;
                din    = x;
                lim_hi = pair_hi[p];
                lim_lo = pair_lo[p];
                h_x[s] = x; h_hi[s] = pair_hi[p]; h_lo[s] = pair_lo[p];
                #2;
                chk("R6 R8 signed", out_s, exp_at(s - 3, -3, -8, 7));
                chk("R7 R8 unsigned", out_u, exp_at(s - 2, 5, 0, 7));
                chk({full_tag(s - 1), " full"}, out_f,
                    exp_at(s - 1, -7777, -2147483647 - 1, 2147483647));
                #4;
                // After the falling edge: only the falling-edge instance moved
                chk("R10 falling update", out_u, exp_at(s - 1, 5, 0, 7));
                chk("R8 signed steady", out_s, exp_at(s - 3, -3, -8, 7));
                chk("R8 full steady", out_f,
                    exp_at(s - 1, -7777, -2147483647 - 1, 2147483647));
                s++;
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule